// File: doc/BRIEF.md
# Multi-Rate Divided Level and Edge Strobe Generator

This block takes one fast system clock and derives three slower square-wave levels from it: one at half the system rate, one at a quarter, and one at a twentieth. With a 20 MHz system clock these come out at 10 MHz, 5 MHz and 1 MHz. The levels are plain logic signals that change on the system clock, so downstream logic can sample them or use them as clock enables. It never has to clock anything from them.

For every derived level the block also gives two strobes, each one system cycle wide. The rise strobe is high in the first system cycle in which the level is high. The fall strobe is high in the first system cycle in which the level is low. The two faster rates are taps of one small free-running binary counter. The slowest rate comes from a mod-ten counter and a toggle register. A parameter selects whether that toggle's strobes come from registers or are decoded from the counter state. Both choices give the same waveforms at the ports.

An asynchronous active-high reset puts every counter, level and strobe at zero.

Top module: `mrs_strobe_gen`

## Requirements
- R1: `lvl_div2_o` is low in the first cycle after reset release and then changes value on every system clock edge, giving a period of 2 system cycles.
- R2: `lvl_div4_o` is low for 2 cycles and then high for 2 cycles, repeating, starting low at reset release.
- R3: `lvl_div20_o` is low for 10 cycles and then high for 10 cycles, repeating, starting low at reset release.
- R4: each rise strobe (`rise_div2_o`, `rise_div4_o`, `rise_div20_o`) is high for exactly one system cycle. That cycle is the first cycle in which its level is high after having been low.
- R5: each fall strobe (`fall_div2_o`, `fall_div4_o`, `fall_div20_o`) is high for exactly one system cycle. That cycle is the first cycle in which its level is low after having been high. No fall strobe appears in the first cycle after reset release, because the level was already low there.
- R6: the rise and fall strobes of the same rate are never high in the same cycle.
- R7: while `rst_i` is high, all nine outputs are 0. Raising `rst_i` forces them to 0 at once, with no clock edge needed.
- R8: consecutive rise strobes of one rate are 2, 4 and 20 system cycles apart for the div-2, div-4 and div-20 outputs. Consecutive fall strobes are spaced the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| lvl_div2_o | output | 1 | Level at system rate / 2 |
| lvl_div4_o | output | 1 | Level at system rate / 4 |
| lvl_div20_o | output | 1 | Level at system rate / 20 |
| rise_div2_o | output | 1 | One-cycle strobe, div-2 level went high |
| fall_div2_o | output | 1 | One-cycle strobe, div-2 level went low |
| rise_div4_o | output | 1 | One-cycle strobe, div-4 level went high |
| fall_div4_o | output | 1 | One-cycle strobe, div-4 level went low |
| rise_div20_o | output | 1 | One-cycle strobe, div-20 level went high |
| fall_div20_o | output | 1 | One-cycle strobe, div-20 level went low |

## Verification
The only inputs are the clock and the reset, so the assertions assume only a free-running clock. They also assume that reset, once released, stays low long enough for `$past` to see values that were written after reset. The edge-relation properties are disabled while reset is high. The one property that checks the zero outputs during reset samples reset itself. The stimulus releases reset on a falling clock edge, so release never coincides with a rising edge. A mid-run reset is asserted between clock edges, which checks its asynchronous effect without racing the counters.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

   // Width of a counter that must hold values 0 .. n-1
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/mrs_binary_taps.sv
module mrs_binary_taps
   import mrs_pkg::*;
#(
   parameter int unsigned TAPS = 2
) (
   input  logic            clk_i,
   input  logic            rst_i,
   output logic [TAPS-1:0] lvl_o,
   output logic [TAPS-1:0] rise_o,
   output logic [TAPS-1:0] fall_o
);

   if (TAPS < 1) begin : g_bad_taps
      $error("mrs_binary_taps: TAPS must be at least 1");
   end

   logic [TAPS-1:0] cnt_q;
   logic            live_q;   // low in the first cycle after reset

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         cnt_q  <= '0;
         live_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
         live_q <= 1'b1;
      end
   end

   for (genvar g = 0; g < TAPS; g++) begin : g_tap
      localparam logic [TAPS-1:0] LOW_MASK = (TAPS'(1) << g) - TAPS'(1);
      logic low_zero;
      assign low_zero  = (cnt_q & LOW_MASK) == '0;
      assign lvl_o[g]  = cnt_q[g];
      assign rise_o[g] = live_q &  cnt_q[g] & low_zero;
      assign fall_o[g] = live_q & ~cnt_q[g] & low_zero;

      // R6
      tap_not_both_chk: assert property (@(posedge clk_i) disable iff (rst_i)
         !(rise_o[g] && fall_o[g]));
      // R4
      tap_rise_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
         rise_o[g] |-> (lvl_o[g] && !$past(lvl_o[g])));
      // R5
      tap_fall_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
         fall_o[g] |-> (!lvl_o[g] && $past(lvl_o[g])));
      // R4
      tap_rise_once_chk: assert property (@(posedge clk_i) disable iff (rst_i)
         rise_o[g] |=> !rise_o[g] || (g == 0));
   end

endmodule

// File: rtl/mrs_toggle_div.sv
module mrs_toggle_div
   import mrs_pkg::*;
#(
   parameter int unsigned HALF        = 10,
   parameter bit          REG_STROBES = 1'b1
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);

   localparam int unsigned CW = cnt_width(HALF);
   localparam logic [CW-1:0] LAST = CW'(HALF - 1);

   if (HALF < 2) begin : g_bad_half
      $error("mrs_toggle_div: HALF must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          lvl_q;
   logic          wrap;

   assign wrap  = (cnt_q == LAST);
   assign lvl_o = lvl_q;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         cnt_q <= '0;
         lvl_q <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         lvl_q <= ~lvl_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   if (REG_STROBES) begin : g_reg_strobe
      logic rise_q, fall_q;
      always_ff @(posedge clk_i or posedge rst_i) begin
         if (rst_i) begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
         end else begin
            rise_q <= wrap & ~lvl_q;
            fall_q <= wrap &  lvl_q;
         end
      end
      assign rise_o = rise_q;
      assign fall_o = fall_q;
   end else begin : g_dec_strobe
      logic live_q;
      always_ff @(posedge clk_i or posedge rst_i) begin
         if (rst_i) live_q <= 1'b0;
         else       live_q <= 1'b1;
      end
      assign rise_o = live_q & (cnt_q == '0) &  lvl_q;
      assign fall_o = live_q & (cnt_q == '0) & ~lvl_q;
   end

   // R3
   cnt_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q <= LAST);
   // R6
   tog_not_both_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !(rise_o && fall_o));
   // R4
   tog_rise_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      rise_o |-> (lvl_o && !$past(lvl_o)));
   // R5
   tog_fall_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      fall_o |-> (!lvl_o && $past(lvl_o)));
   // R4
   tog_strobe_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (rise_o || fall_o) |=> !(rise_o || fall_o));
   // R5
   tog_change_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (lvl_o != $past(lvl_o)) |-> (rise_o || fall_o));

endmodule

// File: rtl/mrs_strobe_gen.sv
module mrs_strobe_gen #(
   parameter int unsigned SLOW_HALF        = 10,
   parameter bit          SLOW_REG_STROBES = 1'b1
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic lvl_div2_o,
   output logic lvl_div4_o,
   output logic lvl_div20_o,
   output logic rise_div2_o,
   output logic fall_div2_o,
   output logic rise_div4_o,
   output logic fall_div4_o,
   output logic rise_div20_o,
   output logic fall_div20_o
);

   localparam int unsigned FAST_TAPS = 2;

   logic [FAST_TAPS-1:0] tap_lvl, tap_rise, tap_fall;

   mrs_binary_taps #(.TAPS(FAST_TAPS)) fast_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .lvl_o  (tap_lvl),
      .rise_o (tap_rise),
      .fall_o (tap_fall)
   );

   mrs_toggle_div #(.HALF(SLOW_HALF), .REG_STROBES(SLOW_REG_STROBES)) slow_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .lvl_o  (lvl_div20_o),
      .rise_o (rise_div20_o),
      .fall_o (fall_div20_o)
   );

   assign lvl_div2_o  = tap_lvl[0];
   assign lvl_div4_o  = tap_lvl[1];
   assign rise_div2_o = tap_rise[0];
   assign fall_div2_o = tap_fall[0];
   assign rise_div4_o = tap_rise[1];
   assign fall_div4_o = tap_fall[1];

   // R7
   reset_quiet_chk: assert property (@(posedge clk_i)
      rst_i |-> !(lvl_div2_o || lvl_div4_o || lvl_div20_o ||
                  rise_div2_o || fall_div2_o || rise_div4_o ||
                  fall_div4_o || rise_div20_o || fall_div20_o));
   // R2
   div4_follows_div2_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(lvl_div2_o) |-> (lvl_div4_o != $past(lvl_div4_o)));

endmodule

// File: tb/mrs_strobe_gen_tb_top.sv
module mrs_strobe_gen_tb_top;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic l2, l4, l20, r2, f2, r4, f4, r20, f20;
   int   total = 0;
   int   bad   = 0;
   bit   done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   mrs_strobe_gen dut_i (
      .clk_i(clk), .rst_i(rst),
      .lvl_div2_o(l2), .lvl_div4_o(l4), .lvl_div20_o(l20),
      .rise_div2_o(r2), .fall_div2_o(f2),
      .rise_div4_o(r4), .fall_div4_o(f4),
      .rise_div20_o(r20), .fall_div20_o(f20)
   );

   // Expected {levels}, {rises}, {falls} (bit order div20,div4,div2) after n edges
   function automatic logic [8:0] expect_vec(input int n);
      logic [2:0] lv, rs, fl;
      lv = {((n / 10) % 2) == 1, (n % 4) >= 2, (n % 2) == 1};
      rs = {(n % 20) == 10, (n % 4) == 2, (n % 2) == 1};
      fl = {(n % 20) == 0 && n > 0, (n % 4) == 0 && n > 0, (n % 2) == 0 && n > 0};
      return {lv, rs, fl};
   endfunction

   task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp, input int n);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s cycle %0d: actual=%b expected=%b", req, n, act, exp);
      end
   endtask

   // Walk n cycles from a fresh reset release; checks R1..R6 and R8
   task automatic run_cycles(input int cycles);
      int last_r [3];
      int last_f [3];
      int gap [3];
      logic [8:0] e;
      gap = '{2, 4, 20};
      last_r = '{-1, -1, -1};
      last_f = '{-1, -1, -1};
      for (int n = 0; n < cycles; n++) begin
         if (n > 0) @(negedge clk);
         else #1;
         e = expect_vec(n);
         check("R1/R2/R3 levels", {l20, l4, l2}, e[8:6], n);
         check("R4 rise strobes", {r20, r4, r2}, e[5:3], n);
         check("R5 fall strobes", {f20, f4, f2}, e[2:0], n);
         check("R6 exclusive", {r20 & f20, r4 & f4, r2 & f2}, 3'b000, n);
         for (int k = 0; k < 3; k++) begin
            logic rv, fv;
            rv = (k == 0) ? r2 : (k == 1) ? r4 : r20;
            fv = (k == 0) ? f2 : (k == 1) ? f4 : f20;
            if (rv) begin
               if (last_r[k] >= 0) begin
                  total++;
                  if (n - last_r[k] != gap[k]) begin
                     bad++;
                     $display("FAIL R8 rise gap rate%0d: actual=%0d expected=%0d", k, n - last_r[k], gap[k]);
                  end
               end
               last_r[k] = n;
            end
            if (fv) begin
               if (last_f[k] >= 0) begin
                  total++;
                  if (n - last_f[k] != gap[k]) begin
                     bad++;
                     $display("FAIL R8 fall gap rate%0d: actual=%0d expected=%0d", k, n - last_f[k], gap[k]);
                  end
               end
               last_f[k] = n;
            end
         end
      end
   endtask

   initial begin
      // R7: outputs quiet while reset is held across edges
      repeat (3) @(negedge clk);
      check("R7 reset levels", {l20, l4, l2}, 3'b000, -1);
      check("R7 reset strobes", {r20 | f20, r4 | f4, r2 | f2}, 3'b000, -1);
      rst = 1'b0;
      run_cycles(65);
      // R7: asynchronous reset between edges clears at once
      @(negedge clk);
      #3 rst = 1'b1;
      #1;
      check("R7 async levels", {l20, l4, l2}, 3'b000, -2);
      check("R7 async strobes", {r20 | f20, r4 | f4, r2 | f2}, 3'b000, -2);
      @(negedge clk);
      rst = 1'b0;
      // Restart from mid-run reset: same sequence again
      run_cycles(45);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule